// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a single-stage, non-blocking switch for eight serial PCM links. Each link carries 32 byte-wide time slots per frame, so the switch has 256 input channels and 256 output channels. Every input byte is converted to parallel form and stored in a speech memory. For each output link and slot, a control table holds one entry. The entry either points at any stored speech byte or carries a literal byte to transmit. The selected byte is serialized again onto the output link. A one-cycle frame pulse reloads two free-running timebases. The input timebase runs one slot behind true time and drives the writes. The output timebase runs two slots ahead and drives the table reads. Both are derived from the master clock by power-of-two division: four clocks per bit, eight bits per slot, 32 slots per frame.

A controller fills the inactive copy of the control table and then asks for a swap. The swap takes place on an output-frame boundary, so every frame is switched by one complete table. During the idle phases of a slot, the same port can read any speech-memory byte. It can also capture the slot-0 byte of a chosen input link. Two small state machines govern this. The access machine has the states P_IDLE, P_READ and P_CAPT. P_IDLE goes to P_CAPT on `cap_req`, or to P_READ on `rd_req`. P_READ returns to P_IDLE at the first idle phase. P_CAPT returns to P_IDLE at the first idle phase of input slot 0. The bank machine has the states B_HOLD and B_ARMED. B_HOLD goes to B_ARMED on `cfg_swap`. B_ARMED flips the active table and returns to B_HOLD at the last clock of an output frame.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held and right after it is released, every `dout` bit and `rd_valid` are 0.
- R2: A control entry with bit 8 = 0 sends the speech byte at address bits 7:0. Bits 7:5 of that address are the input link and bits 4:0 are the input slot. Slots are numbered absolutely from the frame pulse. Output slot O then carries input slot A of that link, where A is the largest value with A ≤ O−3 and A mod 32 equal to the addressed slot.
- R3: A control entry with bit 8 = 1 sends its bits 7:0 unchanged.
- R4: Serial bytes travel MSB first. Each bit is held for 4 clocks. Inputs are sampled on the second clock of each bit.
- R5: The clock in which `fsync` is sampled high is the first clock of bit 7 of slot 0 on every link, in both directions. The output timebase always leads the input timebase by three slots.
- R6: After `cfg_swap`, the other table governs output from the next output frame. That frame's slot 0 is read two slots before it is sent. A request made before the last two slots of a frame therefore affects the next frame's slot 0 onward.
- R7: `cfg_we` writes entry `cfg_addr` = {output link, output slot} in the inactive table only. It has no effect on the output until a swap.
- R8: `rd_req` is served at the first idle phase, phases 16–31 of a slot. It gives a one-clock `rd_valid` pulse with the speech byte at `rd_addr`. A request made at phase 0 of a slot is answered 17 clocks later.
- R9: `cap_req` returns the slot-0 byte of link `cap_link`. The byte comes from the first input slot 0 stored after the request. `rd_valid` rises at phase 16 of the input-timebase slot 0 plus one clock.
- R10: While a read or capture is pending, new `rd_req` and `cap_req` are ignored. If both arrive together, `cap_req` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-clock frame pulse |
| din | input | 8 | Serial input links |
| dout | output | 8 | Serial output links |
| cfg_we | input | 1 | Write one control entry in the inactive table |
| cfg_addr | input | 8 | Entry index {output link, output slot} |
| cfg_data | input | 9 | Entry: bit 8 literal flag, bits 7:0 address or byte |
| cfg_swap | input | 1 | Request a table swap at the next output frame |
| rd_req | input | 1 | Request a speech-memory read |
| rd_addr | input | 8 | Speech address {input link, input slot} |
| cap_req | input | 1 | Request a slot-0 capture |
| cap_link | input | 3 | Input link to capture |
| rd_valid | output | 1 | One-clock pulse: `rd_data` is valid |
| rd_data | output | 8 | Read or captured byte |

## Verification
Two full tables of mixed pointer and literal entries are loaded. Every output slot of several frames is compared with a byte computed from the absolute-slot rule. This exposes three kinds of error. A latency that is off by one slot shifts source bytes around the frame wrap. A wrong address split picks the wrong link. A wrong bit order or bit length scrambles the bytes. The second table is written while the first one is live, and then swapped. A design that writes the live bank, or swaps at the wrong edge, corrupts the frames on either side of slot 128. Readback and capture are checked to the exact clock and byte. Requests made while the access machine is busy must produce no extra pulse. A design that fails to ignore them would produce a pulse late in the run.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [1:0] {P_IDLE, P_READ, P_CAPT} acc_st_t;
    typedef enum logic {B_HOLD, B_ARMED} bank_st_t;
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase #(
    parameter int CW     = 10,
    parameter int PRESET = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LOAD_V  = CW'(PRESET);
    localparam logic [CW-1:0] RESET_V = CW'(PRESET - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= RESET_V;
        else if (fsync) cnt <= LOAD_V;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
    parameter int PW = 2,
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       din,
    input  logic [PW+$clog2(DW)-1:0]   phase,
    output logic [DW-1:0]              word
);
    localparam int PHW = PW + $clog2(DW);
    logic [DW-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            word  <= '0;
        end else begin
            if (phase[PW-1:0] == PW'(1)) shreg <= {shreg[DW-2:0], din};
            if (phase == {PHW{1'b1}})    word  <= shreg;
        end
    end
endmodule

// File: rtl/tsi_smem.sv
module tsi_smem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [0:(1<<AW)-1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int NLINK = 8,
    parameter int NSLOT = 32,
    parameter int SUB   = 4,
    parameter int DW    = 8,
    localparam int LW   = $clog2(NLINK),
    localparam int SW   = $clog2(NSLOT),
    localparam int PW   = $clog2(SUB),
    localparam int PHW  = PW + $clog2(DW),
    localparam int CW   = SW + PHW,
    localparam int AW   = LW + SW,
    localparam int EW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    out_cnt,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [EW-1:0]    cfg_data,
    input  logic             cfg_swap,
    output logic [AW-1:0]    sm_raddr,
    input  logic [DW-1:0]    sm_rdata,
    output logic [NLINK-1:0] dout,
    output logic             act_bank
);
    logic [EW-1:0] cm [0:(1<<(AW+1))-1];
    bank_st_t      bst, bst_nx;

    logic [PHW-1:0] phase;
    logic [SW-1:0]  slot;
    logic           frame_end, slot_end, bit_end, rd_win;
    logic [LW-1:0]  rlink;
    logic [EW-1:0]  entry;
    logic [DW-1:0]  byte_sel;

    assign phase     = out_cnt[PHW-1:0];
    assign slot      = out_cnt[CW-1:PHW];
    assign frame_end = (out_cnt == {CW{1'b1}});
    assign slot_end  = (phase == {PHW{1'b1}});
    assign bit_end   = (phase[PW-1:0] == {PW{1'b1}});
    assign rd_win    = (phase >= PHW'(NLINK)) && (phase < PHW'(2*NLINK));
    assign rlink     = LW'(phase - PHW'(NLINK));
    assign entry     = cm[{act_bank, rlink, slot}];
    assign sm_raddr  = entry[AW-1:0];
    assign byte_sel  = entry[AW] ? entry[DW-1:0] : sm_rdata;

    // shadow-bank writes
    always_ff @(posedge clk) begin
        if (cfg_we) cm[{~act_bank, cfg_addr}] <= cfg_data;
    end

    // bank state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bst <= B_HOLD;
        else        bst <= bst_nx;
    end

    always_comb begin
        bst_nx = bst;
        unique case (bst)
            B_HOLD:  if (cfg_swap)  bst_nx = B_ARMED;
            B_ARMED: if (frame_end) bst_nx = B_HOLD;
            default: bst_nx = B_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           act_bank <= 1'b0;
        else if (bst == B_ARMED && frame_end) act_bank <= ~act_bank;
    end

    // per-link fetch, hold and serialize stages
    for (genvar l = 0; l < NLINK; l++) begin : g_link
        logic [DW-1:0] fetch_q, hold_q, ser_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fetch_q <= '0;
                hold_q  <= '0;
                ser_q   <= '0;
            end else begin
                if (rd_win && rlink == LW'(l)) fetch_q <= byte_sel;
                if (slot_end) begin
                    hold_q <= fetch_q;
                    ser_q  <= hold_q;
                end else if (bit_end) begin
                    ser_q <= {ser_q[DW-2:0], 1'b0};
                end
            end
        end
        assign dout[l] = ser_q[DW-1];
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NLINK = 8,
    parameter int NSLOT = 32,
    parameter int SUB   = 4,
    localparam int DW    = 8,
    localparam int LW    = $clog2(NLINK),
    localparam int SW    = $clog2(NSLOT),
    localparam int PW    = $clog2(SUB),
    localparam int PHW   = PW + $clog2(DW),
    localparam int CW    = SW + PHW,
    localparam int AW    = LW + SW,
    localparam int EW    = AW + 1,
    localparam int SLOTC = SUB * DW,
    localparam int FRAMC = NSLOT * SLOTC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [NLINK-1:0] din,
    output logic [NLINK-1:0] dout,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [EW-1:0]    cfg_data,
    input  logic             cfg_swap,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    input  logic             cap_req,
    input  logic [LW-1:0]    cap_link,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    logic [CW-1:0]  in_cnt, out_cnt;
    logic [PHW-1:0] in_phase;
    logic [SW-1:0]  in_slot;
    logic [DW-1:0]  words [NLINK];
    logic [LW-1:0]  wlink;
    logic           wr_en, idle_ph, cap_hit, cm_bank;
    logic [AW-1:0]  sm_raddr, req_addr;
    logic [DW-1:0]  sm_rdata, sm_bdata;
    acc_st_t        st, st_nx;

    tsi_timebase #(.CW(CW), .PRESET(FRAMC - SLOTC + 1)) u_in_tb (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .cnt(in_cnt));
    tsi_timebase #(.CW(CW), .PRESET(2 * SLOTC + 1)) u_out_tb (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .cnt(out_cnt));

    assign in_phase = in_cnt[PHW-1:0];
    assign in_slot  = in_cnt[CW-1:PHW];

    for (genvar l = 0; l < NLINK; l++) begin : g_rx
        tsi_rx_lane #(.PW(PW), .DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n), .din(din[l]),
            .phase(in_phase), .word(words[l]));
    end

    assign wr_en   = (in_phase < PHW'(NLINK));
    assign wlink   = LW'(in_phase);
    assign idle_ph = (in_phase >= PHW'(2 * NLINK));
    assign cap_hit = idle_ph && (in_slot == '0);

    tsi_smem #(.AW(AW), .DW(DW)) u_sm (
        .clk(clk), .we(wr_en), .waddr({wlink, in_slot}), .wdata(words[wlink]),
        .raddr_a(sm_raddr), .rdata_a(sm_rdata),
        .raddr_b(req_addr), .rdata_b(sm_bdata));

    tsi_tx #(.NLINK(NLINK), .NSLOT(NSLOT), .SUB(SUB), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .out_cnt(out_cnt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_swap(cfg_swap), .sm_raddr(sm_raddr), .sm_rdata(sm_rdata),
        .dout(dout), .act_bank(cm_bank));

    // access state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= P_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            P_IDLE: begin
                if (cap_req)     st_nx = P_CAPT;
                else if (rd_req) st_nx = P_READ;
            end
            P_READ:  if (idle_ph) st_nx = P_IDLE;
            P_CAPT:  if (cap_hit) st_nx = P_IDLE;
            default: st_nx = P_IDLE;
        endcase
    end

    // access outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            req_addr <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                P_IDLE: begin
                    if (cap_req)     req_addr <= {cap_link, SW'(0)};
                    else if (rd_req) req_addr <= rd_addr;
                end
                P_READ: if (idle_ph) begin
                    rd_valid <= 1'b1;
                    rd_data  <= sm_bdata;
                end
                P_CAPT: if (cap_hit) begin
                    rd_valid <= 1'b1;
                    rd_data  <= sm_bdata;
                end
                default: rd_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int CW    = 10,
    parameter int PHW   = 5,
    parameter int AW    = 8,
    parameter int NLINK = 8,
    parameter int SLOTC = 32,
    parameter int FRAMC = 1024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fsync,
    input logic [CW-1:0] in_cnt,
    input logic [CW-1:0] out_cnt,
    input acc_st_t       st,
    input logic [AW-1:0] req_addr,
    input logic          rd_valid,
    input logic          cm_bank
);
    // R5
    tb_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt - in_cnt) == CW'(3 * SLOTC));

    // R5
    sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (out_cnt == CW'(2 * SLOTC + 1)) && (in_cnt == CW'(FRAMC - SLOTC + 1)));

    // R6
    swap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cm_bank) |-> $past(out_cnt) == {CW{1'b1}});

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(in_cnt[PHW-1:0]) >= PHW'(2 * NLINK));

    // R9
    cap_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(st) == P_CAPT) |-> $past(in_cnt[CW-1:PHW]) == '0);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != P_IDLE && $past(st) != P_IDLE) |-> $stable(req_addr));
endmodule

bind tsi_switch tsi_switch_chk #(
    .CW(CW), .PHW(PHW), .AW(AW), .NLINK(NLINK), .SLOTC(SLOTC), .FRAMC(FRAMC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_cnt(in_cnt), .out_cnt(out_cnt),
    .st(st), .req_addr(req_addr), .rd_valid(rd_valid), .cm_bank(cm_bank));

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [8:0] cfg_data = '0;
    logic       cfg_swap = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       cap_req = 1'b0;
    logic [2:0] cap_link = '0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    localparam int NT = 6400;

    always #4 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .din(din), .dout(dout),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_swap(cfg_swap), .rd_req(rd_req), .rd_addr(rd_addr),
        .cap_req(cap_req), .cap_link(cap_link),
        .rd_valid(rd_valid), .rd_data(rd_data));

    function automatic logic [7:0] in_byte(int l, int a);
        int v;
        v = l * 151 + a * 89 + (a >> 3) * 7 + 17;
        return 8'(v ^ (a >> 2));
    endfunction

    function automatic logic [8:0] tab1(int i);
        return (i % 5 == 0) ? {1'b1, 8'(i ^ 8'hA5)} : {1'b0, 8'(i * 37 + 11)};
    endfunction

    function automatic logic [8:0] tab2(int i);
        return (i % 3 == 0) ? {1'b1, 8'(~i)} : {1'b0, 8'(i * 101 + 3)};
    endfunction

    function automatic logic [8:0] entry_at(int l, int o);
        int idx;
        idx = l * 32 + (o % 32);
        return (o < 128) ? tab1(idx) : tab2(idx);
    endfunction

    // R2 latency rule: latest input slot A <= O-3 in the addressed slot
    function automatic logic [7:0] exp_out(int l, int o);
        logic [8:0] e;
        int j, sl, a;
        e = entry_at(l, o);
        if (e[8]) return e[7:0];
        j  = int'(e[4:0]);
        sl = int'(e[7:5]);
        a  = (o - 3) - ((((o - 3 - j) % 32) + 32) % 32);
        return in_byte(sl, a);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got [8];
        int w1 = 0;
        int w2 = 0;
        repeat (3) @(negedge clk);
        check("R1 dout in reset", 32'(dout), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 dout after reset", 32'(dout), 32'h0);
        check("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
        for (int tt = 0; tt < NT; tt++) begin
            @(negedge clk);
            // sample outputs for counter value tt
            if (tt % 4 == 1) begin
                for (int l = 0; l < 8; l++) got[l][7 - ((tt >> 2) & 7)] = dout[l];
            end
            if (tt % 32 == 29 && (tt >> 5) >= 64) begin
                int o;
                o = tt >> 5;
                for (int l = 0; l < 8; l++) begin
                    string tag;
                    if (o >= 128 && o <= 131)  tag = "R6 swap boundary";
                    else if (o < 96)           tag = "R5 frame alignment";
                    else if (o < 128)          tag = "R7 shadow writes";
                    else if (o >= 160)         tag = "R4 serial order";
                    else if (entry_at(l, o)[8]) tag = "R3 literal";
                    else                       tag = "R2 switched";
                    check(tag, 32'(got[l]), 32'(exp_out(l, o)));
                end
            end
            if (rd_valid && tt >= 4256 && tt < 5440) w1++;
            if (rd_valid && tt >= 5458) w2++;
            if (tt == 5168) check("R9 capture not early", 32'(rd_valid), 32'h0);
            if (tt == 5169) begin
                check("R9 capture valid", 32'(rd_valid), 32'h1);
                check("R9 capture data", 32'(rd_data), 32'(in_byte(6, 160)));
            end
            if (tt == 5456) check("R8 read not early", 32'(rd_valid), 32'h0);
            if (tt == 5457) begin
                check("R8 read valid", 32'(rd_valid), 32'h1);
                check("R8 read data", 32'(rd_data), 32'(in_byte(3, 167)));
            end
            // drive inputs for counter value tt
            fsync = (tt % 1024 == 0);
            for (int l = 0; l < 8; l++) begin
                logic [7:0] b;
                b = in_byte(l, tt >> 5);
                din[l] = b[7 - ((tt >> 2) & 7)];
            end
            cfg_we = 1'b0;
            if (tt >= 100 && tt < 356) begin
                cfg_we   = 1'b1;
                cfg_addr = 8'(tt - 100);
                cfg_data = tab1(tt - 100);
            end
            if (tt >= 2148 && tt < 2404) begin
                cfg_we   = 1'b1;
                cfg_addr = 8'(tt - 2148);
                cfg_data = tab2(tt - 2148);
            end
            cfg_swap = (tt == 400) || (tt == 3472);
            cap_req  = (tt == 4256) || (tt == 5445);
            cap_link = (tt == 4256) ? 3'd6 : 3'd2;
            rd_req   = (tt == 4266) || (tt == 5440);
            rd_addr  = (tt == 5440) ? {3'd3, 5'd7} : 8'h11;
        end
        check("R10 one pulse during capture", 32'(w1), 32'h1);
        check("R10 no pulse from ignored capture", 32'(w2), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule